// File: doc/BRIEF.md
# Frame-Synchronous Sample-to-PWM Modulator

This block turns a stream of digital samples, such as the output of a separate sine generator, into a fixed-frequency pulse-width-modulated waveform that drives a class-D power stage. A period timer splits the main clock into frames of a fixed length, 200 cycles by default. Near the end of each frame the block asks upstream logic for the next sample.

At the start of each frame the block takes one sample, limits it to the amplifier's permitted duty window, and loads it into a down-counter. The output goes high at the frame start. The counter then steps down once per clock, and the output drops when the counter runs out. A sample of value N therefore gives exactly N high cycles in that frame. The sample rate equals the switching rate: for example, a 50 MHz clock gives a 250 kHz output.

The frame length and both limits of the duty window are parameters. Out-of-range samples are pulled into the window, so the amplifier never sees a pulse that is too short or too long.

Top module: `frame_pwm_mod`

## Requirements
- R1: `sample_req_o` is a one-cycle pulse that repeats every FRAME_LEN (default 200) clock cycles and is low in every other cycle.
- R2: The sample value is taken only at the clock edge that ends a cycle in which `sample_req_o` is high. Changes to `sample_i` in any other cycle have no effect on the waveform.
- R3: `pwm_o` is high in the first cycle of every frame, which is the cycle directly after a `sample_req_o` cycle.
- R4: For a taken sample N with DUTY_MIN <= N <= DUTY_MAX (default 4 to 196), `pwm_o` is high for exactly N consecutive cycles from the frame start. It is low for the remaining FRAME_LEN-N cycles of that frame.
- R5: A taken sample below DUTY_MIN, including 0, gives a high time of exactly DUTY_MIN cycles.
- R6: A taken sample above DUTY_MAX, up to the 8-bit maximum of 255, gives a high time of exactly DUTY_MAX cycles.
- R7: `rst_n` is an active-low synchronous reset. While it is low, `pwm_o` and `sample_req_o` are low. Counting from the first cycle after release as cycle 0, `sample_req_o` first rises in cycle FRAME_LEN-1, and `pwm_o` stays low until the frame that follows.
- R8: Consecutive frames each use their own sample, with no gap between frames, so every frame's high time follows R4 to R6 for the sample taken at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; one frame is FRAME_LEN cycles |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_i | input | SAMPLE_W | Duty sample in clock cycles, taken at frame start |
| sample_req_o | output | 1 | High in the last cycle of each frame; present the next sample here |
| pwm_o | output | 1 | Pulse-width-modulated output |

## Verification
The bench drives the two ends of the duty window and the values just outside them: 0, 3, 4, 5, 195, 196, 197 and 255. An off-by-one counter would give N±1 high cycles, and a missing or reversed limit would let a 0 or 255 through unchanged. Between sample-request pulses it drives junk on the sample input, so a design that loads the sample continuously shows a wrong high time. It measures the delay from reset release to the first request, and it applies a reset in the middle of a pulse. Together these catch a timer that starts at the wrong count or an output that is not cleared by reset.

// File: rtl/sdpwm_pkg.sv
// Package: helpers shared by the modulator and its checker.
// Assumes values fit in 32 bits and that lo <= hi.
package sdpwm_pkg;

    // Limit a value to the closed range [lo, hi].
    function automatic int unsigned clip_to(input int unsigned v,
                                            input int unsigned lo,
                                            input int unsigned hi);
        if (v < lo)
            return lo;
        else if (v > hi)
            return hi;
        else
            return v;
    endfunction

endpackage

// File: rtl/frame_timer.sv
// Frame timer: counts 0 .. FRAME_LEN-1 and raises last_o in the final
// cycle of every frame.
// Assumes FRAME_LEN >= 2. Reset is synchronous and active low; it restarts at 0.
module frame_timer #(
    parameter int unsigned FRAME_LEN = 200
) (
    input  logic clk,
    input  logic rst_n,
    output logic last_o
);
    localparam int unsigned TW = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
    localparam logic [TW-1:0] LAST = TW'(FRAME_LEN - 1);

    logic [TW-1:0] tick_q;

    // Advance the position within the frame and wrap after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tick_q <= '0;
        else if (tick_q == LAST)
            tick_q <= '0;
        else
            tick_q <= tick_q + 1'b1;
    end

    assign last_o = (tick_q == LAST);
endmodule

// File: rtl/duty_clamp.sv
// Duty clamp: pulls a raw sample into [DUTY_MIN, DUTY_MAX].
// Purely combinational. Assumes DUTY_MAX fits in SAMPLE_W bits.
module duty_clamp
    import sdpwm_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 8,
    parameter int unsigned DUTY_MIN = 4,
    parameter int unsigned DUTY_MAX = 196
) (
    input  logic [SAMPLE_W-1:0] raw_i,
    output logic [SAMPLE_W-1:0] lim_o
);
    // Limit the sample to the permitted duty window.
    always_comb begin
        lim_o = SAMPLE_W'(clip_to(int'(raw_i), DUTY_MIN, DUTY_MAX));
    end
endmodule

// File: rtl/pulse_counter.sv
// Pulse counter: on load_i, takes a count N and raises the output.
// The count drops by one each cycle, and the output falls once N cycles
// have passed. Assumes a new load never arrives while the count is
// still running, unless N is the full frame length.
module pulse_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] value_i,
    output logic             pwm_o
);
    logic [CNT_W-1:0] left_q;
    logic             pwm_q;

    // Load on frame start, then count down and drop the output at the last high cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
            pwm_q  <= 1'b0;
        end else if (load_i) begin
            left_q <= value_i;
            pwm_q  <= (value_i != '0);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
            if (left_q == CNT_W'(1))
                pwm_q <= 1'b0;
        end
    end

    assign pwm_o = pwm_q;
endmodule

// File: rtl/frame_pwm_mod.sv
// Top: sample-loaded down-counter PWM modulator.
// One sample is taken per FRAME_LEN-cycle frame, at the edge that ends the
// sample_req_o cycle. It is clamped to the duty window, and its value sets
// the number of high cycles.
// Assumes 1 <= DUTY_MIN <= DUTY_MAX <= FRAME_LEN and 2**SAMPLE_W > DUTY_MAX.
module frame_pwm_mod #(
    parameter int unsigned SAMPLE_W  = 8,
    parameter int unsigned FRAME_LEN = 200,
    parameter int unsigned DUTY_MIN  = 4,
    parameter int unsigned DUTY_MAX  = 196
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic                sample_req_o,
    output logic                pwm_o
);
    logic                frame_last;
    logic [SAMPLE_W-1:0] duty_lim;

    frame_timer #(.FRAME_LEN(FRAME_LEN)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .last_o (frame_last)
    );

    duty_clamp #(
        .SAMPLE_W (SAMPLE_W),
        .DUTY_MIN (DUTY_MIN),
        .DUTY_MAX (DUTY_MAX)
    ) u_clamp (
        .raw_i (sample_i),
        .lim_o (duty_lim)
    );

    pulse_counter #(.CNT_W(SAMPLE_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (frame_last),
        .value_i (duty_lim),
        .pwm_o   (pwm_o)
    );

    assign sample_req_o = frame_last;
endmodule

// File: rtl/frame_pwm_mod_chk.sv
// Checker for frame_pwm_mod: watches only the top-level ports.
// It rebuilds frame spacing and expected high times with its own counters.
module frame_pwm_mod_chk
    import sdpwm_pkg::*;
#(
    parameter int unsigned SAMPLE_W  = 8,
    parameter int unsigned FRAME_LEN = 200,
    parameter int unsigned DUTY_MIN  = 4,
    parameter int unsigned DUTY_MAX  = 196
) (
    input logic                clk,
    input logic                rst_n,
    input logic [SAMPLE_W-1:0] sample_i,
    input logic                sample_req_o,
    input logic                pwm_o
);
    int unsigned gap_q;
    int unsigned hi_q;
    int unsigned exp_q;
    logic        seen_q;

    // Track cycles since the last request, the high time, and the expected duty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= 0;
            hi_q   <= 0;
            exp_q  <= 0;
            seen_q <= 1'b0;
        end else if (sample_req_o) begin
            gap_q  <= 0;
            hi_q   <= 0;
            exp_q  <= clip_to(int'(sample_i), DUTY_MIN, DUTY_MAX);
            seen_q <= 1'b1;
        end else begin
            gap_q <= gap_q + 1;
            if (pwm_o)
                hi_q <= hi_q + 1;
        end
    end

    // R1
    frame_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_req_o == (gap_q == FRAME_LEN - 1));

    // R3
    high_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_req_o |=> pwm_o);

    // R2
    rise_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_o) |-> $past(sample_req_o));

    // R4
    high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwm_o) |-> (hi_q == exp_q));

    // R7
    idle_before_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> !pwm_o);

    // R6
    low_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && sample_req_o && (DUTY_MAX < FRAME_LEN)) |-> !pwm_o);
endmodule

bind frame_pwm_mod frame_pwm_mod_chk #(
    .SAMPLE_W  (SAMPLE_W),
    .FRAME_LEN (FRAME_LEN),
    .DUTY_MIN  (DUTY_MIN),
    .DUTY_MAX  (DUTY_MAX)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_i     (sample_i),
    .sample_req_o (sample_req_o),
    .pwm_o        (pwm_o)
);

// File: tb/sim_frame_pwm_mod.sv
// Bench for frame_pwm_mod: directed corner samples and seeded random
// samples. Each frame's waveform is compared with a bench-computed model.
module sim_frame_pwm_mod;
    localparam int FRAME = 200;
    localparam int LO    = 4;
    localparam int HI    = 196;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sample = 8'd0;
    logic       req;
    logic       pwm;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    frame_pwm_mod u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_i     (sample),
        .sample_req_o (req),
        .pwm_o        (pwm)
    );

    always #2.5 clk = ~clk;

    // Expected high time for a taken sample (R4, R5, R6).
    function automatic int exp_high(input int v);
        if (v < LO) return LO;
        if (v > HI) return HI;
        return v;
    endfunction

    task automatic check(input bit ok, input string req_tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
        end
    endtask

    // Entered at the negedge of a request cycle. Presents v, then watches one
    // frame with junk on the input, and returns at the next request cycle.
    task automatic run_frame(input int v, input string req_tag);
        int hi_cnt = 0;
        int shape_err = 0;
        int req_err = 0;
        int n = exp_high(v);
        sample = 8'(v);
        for (int k = 0; k < FRAME; k++) begin
            @(negedge clk);
            if (k == 0) sample = 8'($urandom);   // R2: junk after the take
            if (pwm) hi_cnt++;
            if (pwm != (k < n)) shape_err++;
            if (req != (k == FRAME - 1)) req_err++;
        end
        check(hi_cnt == n, req_tag, hi_cnt, n);
        check(shape_err == 0, "R3/R4 pulse shape", shape_err, 0);
        check(req_err == 0, "R1 request spacing", req_err, 0);
    endtask

    // After reset release at a negedge: request appears first at cycle FRAME-1 (R7).
    task automatic after_release;
        int first = -1;
        int pwm_hi = 0;
        for (int k = 1; k < FRAME; k++) begin
            @(negedge clk);
            if (req && first < 0) first = k;
            if (pwm) pwm_hi++;
        end
        check(first == FRAME - 1, "R7 first request", first, FRAME - 1);
        check(pwm_hi == 0, "R7 output idle before first frame", pwm_hi, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        check(pwm == 1'b0, "R7 pwm in reset", int'(pwm), 0);
        check(req == 1'b0, "R7 request in reset", int'(req), 0);
        rst_n = 1'b1;
        after_release();

        // Directed corners, then back-to-back random frames (R8).
        run_frame(100, "R4 mid");
        run_frame(4,   "R4 min edge");
        run_frame(196, "R4 max edge");
        run_frame(5,   "R4 min+1");
        run_frame(195, "R4 max-1");
        run_frame(0,   "R5 zero");
        run_frame(3,   "R5 below min");
        run_frame(1,   "R5 one");
        run_frame(197, "R6 above max");
        run_frame(255, "R6 full scale");
        for (int i = 0; i < 16; i++)
            run_frame(int'($urandom_range(0, 255)), "R8 random");

        // Mid-pulse reset: start a frame, reset after 10 cycles.
        sample = 8'd150;
        repeat (10) @(negedge clk);
        check(pwm == 1'b1, "R4 high before reset", int'(pwm), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(pwm == 1'b0, "R7 reset clears pwm", int'(pwm), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        after_release();
        run_frame(60, "R4 after reset");
        run_frame(2,  "R5 after reset");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule